// File: doc/BRIEF.md
# Data Access Permission Fault Checker

This block judges one data memory access after its address has been translated. Each request carries:

- the virtual address and the access size in bytes;
- a read/write direction and the current privilege mode;
- a flag saying whether the virtual address is well formed;
- the translation buffer's hit/miss result and the matching entry's permission fields.

The block runs a fixed chain of checks. Alignment comes first, then address validity, then the miss test, then the permission and fault-on tests for the access direction. The first check that fails decides the fault. Later checks are not looked at.

The verdict is registered and reported one cycle after the request. It has three parts: a fault flag, a 3-bit fault kind and an 8-bit status word with one bit per cause. The same clock edge updates six running counters: hits, misses and violations, kept separately for reads and writes.

A small controller with two states sequences the output:

- **S_IDLE**: no verdict is shown.
- **S_REPORT**: the registered verdict is presented.

The transitions are:

- **TR_ACCEPT** (S_IDLE to S_REPORT, when a request arrives).
- **TR_CHAIN** (S_REPORT to S_REPORT, on back-to-back requests).
- **TR_DRAIN** (S_REPORT to S_IDLE, when no request follows).
- **TR_WAIT** (S_IDLE to S_IDLE).

Top module: `dafc_top`

## Requirements
- R1: An access whose address ANDed with (size minus 1) is nonzero gives fault kind 1 (alignment). This check wins over every other check. Its status holds only bit 0 (write), and that bit is set only for writes. No counter changes.
- R2: An aligned access whose address is flagged invalid gives kind 2 (bad address). Its status sets bit 1 (access violation) and bit 4 (bad address), plus bit 0 on writes. It counts one violation in its direction.
- R3: An aligned, valid access that misses gives kind 3, or kind 4 when the page-table-entry request flag is set. Its status sets bit 5 (miss), plus bit 0 on writes. It counts one miss in its direction.
- R4: On a write hit where the write-enable mask bit indexed by the mode number is clear, the kind is 5 (access violation). The status is bits 0 and 1, plus bit 3 (fault-on-write) when the entry's fault-on-write bit is set. It counts one write violation.
- R5: On a write hit that is enabled but has fault-on-write set, the kind is 6 (fault-on) and the status is exactly bits 0 and 3 (0x09). It counts one write violation.
- R6: On a read hit where the read-enable mask bit indexed by the mode number is clear, the kind is 5. The status is bit 1, plus bit 2 (fault-on-read) when the entry's fault-on-read bit is set. It counts one read violation.
- R7: On a read hit that is enabled but has fault-on-read set, the kind is 6 and the status is exactly bit 2 (0x04). It counts one read violation.
- R8: A hit that passes every check gives no fault, kind 0 and status 0. It counts one hit in its direction.
- R9: The verdict appears with out_valid high in the cycle after the request is sampled. In a cycle after no request, out_valid and fault are low and the kind and status read 0.
- R10: After reset, out_valid is low and all six counters read zero.
- R11: A read ignores the write-enable mask and the fault-on-write bit. A write ignores the read-enable mask and the fault-on-read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | VA_W | Virtual address of the access |
| size_bytes | input | SZ_W | Access size in bytes, a power of two |
| is_write | input | 1 | 1 = write, 0 = read |
| mode | input | MODE_W | Current privilege mode, 0 = kernel |
| va_ok | input | 1 | Virtual address is well formed |
| pte_miss_sel | input | 1 | Report a miss as the page-table-entry variant |
| tb_hit | input | 1 | Translation buffer hit |
| rd_en_mask | input | 2**MODE_W | Read enable per mode |
| wr_en_mask | input | 2**MODE_W | Write enable per mode |
| fon_read | input | 1 | Entry faults on read |
| fon_write | input | 1 | Entry faults on write |
| out_valid | output | 1 | Verdict valid |
| fault | output | 1 | The access faulted |
| fault_kind | output | 3 | Fault kind code |
| status | output | 8 | Cause status word |
| rd_hit_cnt | output | CNT_W | Read hits |
| rd_miss_cnt | output | CNT_W | Read misses |
| rd_viol_cnt | output | CNT_W | Read violations |
| wr_hit_cnt | output | CNT_W | Write hits |
| wr_miss_cnt | output | CNT_W | Write misses |
| wr_viol_cnt | output | CNT_W | Write violations |

## Verification
The bench targets the priority chain at its seams. It sends a misaligned access that is also invalid and missing, and an invalid address that also misses. A design that ordered the checks wrongly would report the later cause and bump a counter that must stay still. It exercises the mode-indexed enable bit with masks where only a neighbouring mode is enabled, which catches a mask indexed the wrong way. It also pairs each permission failure with and without the fault-on bit, and applies fault-on bits from the opposite direction. A design that mixed the directions would show a stray status bit or the wrong kind. Back-to-back requests followed by idle cycles catch a verdict that lingers or arrives a cycle late.

// File: rtl/dafc_pkg.sv
package dafc_pkg;

    typedef enum logic [2:0] {
        FK_NONE     = 3'd0,
        FK_ALIGN    = 3'd1,
        FK_BAD_VA   = 3'd2,
        FK_MISS     = 3'd3,
        FK_MISS_PTE = 3'd4,
        FK_ACC_VIOL = 3'd5,
        FK_FAULT_ON = 3'd6
    } fault_kind_e;

    localparam int STATUS_W = 8;
    localparam int SB_WR    = 0;
    localparam int SB_ACV   = 1;
    localparam int SB_FONR  = 2;
    localparam int SB_FONW  = 3;
    localparam int SB_BADVA = 4;
    localparam int SB_MISS  = 5;

    typedef enum logic [1:0] {
        BUMP_NONE = 2'd0,
        BUMP_HIT  = 2'd1,
        BUMP_MISS = 2'd2,
        BUMP_VIOL = 2'd3
    } bump_e;

    typedef struct packed {
        fault_kind_e          kind;
        logic [STATUS_W-1:0]  status;
        bump_e                bump;
        logic                 dir_wr;
    } verdict_t;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } rpt_state_e;

endpackage

// File: rtl/dafc_classify.sv
module dafc_classify
    import dafc_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int SZ_W   = 4,
    parameter int MODE_W = 2
) (
    input  logic [VA_W-1:0]          vaddr,
    input  logic [SZ_W-1:0]          size_bytes,
    input  logic                     is_write,
    input  logic [MODE_W-1:0]        mode,
    input  logic                     va_ok,
    input  logic                     pte_miss_sel,
    input  logic                     tb_hit,
    input  logic [(1<<MODE_W)-1:0]   rd_en_mask,
    input  logic [(1<<MODE_W)-1:0]   wr_en_mask,
    input  logic                     fon_read,
    input  logic                     fon_write,
    output verdict_t                 verdict
);

    logic [VA_W-1:0] size_mask;
    logic            misaligned;
    logic            mode_rd_ok;
    logic            mode_wr_ok;

    assign size_mask  = VA_W'(size_bytes - SZ_W'(1));
    assign misaligned = |(vaddr & size_mask);
    assign mode_rd_ok = rd_en_mask[mode];
    assign mode_wr_ok = wr_en_mask[mode];

    always_comb begin
        verdict        = '0;
        verdict.kind   = FK_NONE;
        verdict.bump   = BUMP_NONE;
        verdict.dir_wr = is_write;

        if (misaligned) begin
            verdict.kind          = FK_ALIGN;
            verdict.status[SB_WR] = is_write;
        end else if (!va_ok) begin
            verdict.kind             = FK_BAD_VA;
            verdict.status[SB_WR]    = is_write;
            verdict.status[SB_ACV]   = 1'b1;
            verdict.status[SB_BADVA] = 1'b1;
            verdict.bump             = BUMP_VIOL;
        end else if (!tb_hit) begin
            verdict.kind            = pte_miss_sel ? FK_MISS_PTE : FK_MISS;
            verdict.status[SB_WR]   = is_write;
            verdict.status[SB_MISS] = 1'b1;
            verdict.bump            = BUMP_MISS;
        end else if (is_write) begin
            if (!mode_wr_ok) begin
                verdict.kind            = FK_ACC_VIOL;
                verdict.status[SB_WR]   = 1'b1;
                verdict.status[SB_ACV]  = 1'b1;
                verdict.status[SB_FONW] = fon_write;
                verdict.bump            = BUMP_VIOL;
            end else if (fon_write) begin
                verdict.kind            = FK_FAULT_ON;
                verdict.status[SB_WR]   = 1'b1;
                verdict.status[SB_FONW] = 1'b1;
                verdict.bump            = BUMP_VIOL;
            end else begin
                verdict.bump = BUMP_HIT;
            end
        end else begin
            if (!mode_rd_ok) begin
                verdict.kind            = FK_ACC_VIOL;
                verdict.status[SB_ACV]  = 1'b1;
                verdict.status[SB_FONR] = fon_read;
                verdict.bump            = BUMP_VIOL;
            end else if (fon_read) begin
                verdict.kind            = FK_FAULT_ON;
                verdict.status[SB_FONR] = 1'b1;
                verdict.bump            = BUMP_VIOL;
            end else begin
                verdict.bump = BUMP_HIT;
            end
        end
    end

endmodule

// File: rtl/dafc_counters.sv
module dafc_counters
    import dafc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bump_en,
    input  logic                  dir_wr,
    input  bump_e                 bump,
    output logic [1:0][CNT_W-1:0] hit_cnt,
    output logic [1:0][CNT_W-1:0] miss_cnt,
    output logic [1:0][CNT_W-1:0] viol_cnt
);

    localparam int NDIR = 2;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic             sel;
        logic [CNT_W-1:0] hit_q;
        logic [CNT_W-1:0] miss_q;
        logic [CNT_W-1:0] viol_q;

        assign sel = bump_en && (dir_wr == (d == 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_q  <= '0;
                miss_q <= '0;
                viol_q <= '0;
            end else if (sel) begin
                unique case (bump)
                    BUMP_HIT:  hit_q  <= hit_q + CNT_W'(1);
                    BUMP_MISS: miss_q <= miss_q + CNT_W'(1);
                    BUMP_VIOL: viol_q <= viol_q + CNT_W'(1);
                    BUMP_NONE: ;
                    default:   ;
                endcase
            end
        end

        assign hit_cnt[d]  = hit_q;
        assign miss_cnt[d] = miss_q;
        assign viol_cnt[d] = viol_q;
    end

endmodule

// File: rtl/dafc_top.sv
module dafc_top
    import dafc_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int SZ_W   = 4,
    parameter int MODE_W = 2,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          vaddr,
    input  logic [SZ_W-1:0]          size_bytes,
    input  logic                     is_write,
    input  logic [MODE_W-1:0]        mode,
    input  logic                     va_ok,
    input  logic                     pte_miss_sel,
    input  logic                     tb_hit,
    input  logic [(1<<MODE_W)-1:0]   rd_en_mask,
    input  logic [(1<<MODE_W)-1:0]   wr_en_mask,
    input  logic                     fon_read,
    input  logic                     fon_write,
    output logic                     out_valid,
    output logic                     fault,
    output logic [2:0]               fault_kind,
    output logic [7:0]               status,
    output logic [CNT_W-1:0]         rd_hit_cnt,
    output logic [CNT_W-1:0]         rd_miss_cnt,
    output logic [CNT_W-1:0]         rd_viol_cnt,
    output logic [CNT_W-1:0]         wr_hit_cnt,
    output logic [CNT_W-1:0]         wr_miss_cnt,
    output logic [CNT_W-1:0]         wr_viol_cnt
);

    localparam int DIR_RD = 0;
    localparam int DIR_WR = 1;

    verdict_t               verdict_d;
    verdict_t               verdict_q;
    rpt_state_e             state_q;
    rpt_state_e             state_d;
    logic [1:0][CNT_W-1:0]  hit_cnt;
    logic [1:0][CNT_W-1:0]  miss_cnt;
    logic [1:0][CNT_W-1:0]  viol_cnt;

    dafc_classify #(
        .VA_W   (VA_W),
        .SZ_W   (SZ_W),
        .MODE_W (MODE_W)
    ) u_classify (
        .vaddr        (vaddr),
        .size_bytes   (size_bytes),
        .is_write     (is_write),
        .mode         (mode),
        .va_ok        (va_ok),
        .pte_miss_sel (pte_miss_sel),
        .tb_hit       (tb_hit),
        .rd_en_mask   (rd_en_mask),
        .wr_en_mask   (wr_en_mask),
        .fon_read     (fon_read),
        .fon_write    (fon_write),
        .verdict      (verdict_d)
    );

    dafc_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump_en  (req_valid),
        .dir_wr   (verdict_d.dir_wr),
        .bump     (verdict_d.bump),
        .hit_cnt  (hit_cnt),
        .miss_cnt (miss_cnt),
        .viol_cnt (viol_cnt)
    );

    // Next-state logic: TR_ACCEPT, TR_CHAIN, TR_DRAIN, TR_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = req_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_d = req_valid ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            verdict_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                verdict_q <= verdict_d;
            end
        end
    end

    always_comb begin
        out_valid  = 1'b0;
        fault      = 1'b0;
        fault_kind = FK_NONE;
        status     = '0;
        unique case (state_q)
            S_IDLE: ;
            S_REPORT: begin
                out_valid  = 1'b1;
                fault      = (verdict_q.kind != FK_NONE);
                fault_kind = verdict_q.kind;
                status     = verdict_q.status;
            end
            default: ;
        endcase
    end

    assign rd_hit_cnt  = hit_cnt[DIR_RD];
    assign rd_miss_cnt = miss_cnt[DIR_RD];
    assign rd_viol_cnt = viol_cnt[DIR_RD];
    assign wr_hit_cnt  = hit_cnt[DIR_WR];
    assign wr_miss_cnt = miss_cnt[DIR_WR];
    assign wr_viol_cnt = viol_cnt[DIR_WR];

endmodule

// File: rtl/dafc_checker.sv
module dafc_checker #(
    parameter int VA_W  = 16,
    parameter int SZ_W  = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  vaddr,
    input logic [SZ_W-1:0]  size_bytes,
    input logic             is_write,
    input logic             va_ok,
    input logic             tb_hit,
    input logic             out_valid,
    input logic             fault,
    input logic [2:0]       fault_kind,
    input logic [7:0]       status,
    input logic [CNT_W-1:0] rd_miss_cnt
);

    logic off_boundary;
    assign off_boundary = |(vaddr & VA_W'(size_bytes - SZ_W'(1)));

    a_r9_report_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r9_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !fault && status == 8'h00));

    a_r8_clean_zero_status: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault_kind == 3'd0) |-> (status == 8'h00 && !fault));

    a_r1_alignment_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && off_boundary) |=> (fault_kind == 3'd1 && status[7:1] == 7'd0));

    a_r2_bad_va_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !off_boundary && !va_ok) |=>
            (fault_kind == 3'd2 && status[4] && status[1]));

    a_r7_fonr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fault_kind == 3'd6 && !status[0]) |-> (status == 8'h04));

    a_r3_read_miss_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !off_boundary && va_ok && !tb_hit && !is_write) |=>
            (rd_miss_cnt == $past(rd_miss_cnt) + CNT_W'(1)));

endmodule

bind dafc_top dafc_checker #(
    .VA_W  (VA_W),
    .SZ_W  (SZ_W),
    .CNT_W (CNT_W)
) u_dafc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vaddr       (vaddr),
    .size_bytes  (size_bytes),
    .is_write    (is_write),
    .va_ok       (va_ok),
    .tb_hit      (tb_hit),
    .out_valid   (out_valid),
    .fault       (fault),
    .fault_kind  (fault_kind),
    .status      (status),
    .rd_miss_cnt (rd_miss_cnt)
);

// File: tb/tb_dafc_top.sv
module tb_dafc_top;

    localparam int VA_W   = 16;
    localparam int SZ_W   = 4;
    localparam int MODE_W = 2;
    localparam int CNT_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  vaddr = '0;
    logic [SZ_W-1:0]  size_bytes = 4'd1;
    logic             is_write = 1'b0;
    logic [MODE_W-1:0] mode = '0;
    logic             va_ok = 1'b1;
    logic             pte_miss_sel = 1'b0;
    logic             tb_hit = 1'b1;
    logic [3:0]       rd_en_mask = 4'hF;
    logic [3:0]       wr_en_mask = 4'hF;
    logic             fon_read = 1'b0;
    logic             fon_write = 1'b0;
    logic             out_valid;
    logic             fault;
    logic [2:0]       fault_kind;
    logic [7:0]       status;
    logic [CNT_W-1:0] rd_hit_cnt, rd_miss_cnt, rd_viol_cnt;
    logic [CNT_W-1:0] wr_hit_cnt, wr_miss_cnt, wr_viol_cnt;

    int checks = 0;
    int fails  = 0;
    int cnt_model[6];

    always #2 clk = ~clk;

    dafc_top #(
        .VA_W(VA_W), .SZ_W(SZ_W), .MODE_W(MODE_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
        .size_bytes(size_bytes), .is_write(is_write), .mode(mode),
        .va_ok(va_ok), .pte_miss_sel(pte_miss_sel), .tb_hit(tb_hit),
        .rd_en_mask(rd_en_mask), .wr_en_mask(wr_en_mask),
        .fon_read(fon_read), .fon_write(fon_write),
        .out_valid(out_valid), .fault(fault), .fault_kind(fault_kind),
        .status(status), .rd_hit_cnt(rd_hit_cnt), .rd_miss_cnt(rd_miss_cnt),
        .rd_viol_cnt(rd_viol_cnt), .wr_hit_cnt(wr_hit_cnt),
        .wr_miss_cnt(wr_miss_cnt), .wr_viol_cnt(wr_viol_cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_counters(input string req);
        chk(req, "rd_hit_cnt",  int'(rd_hit_cnt),  cnt_model[0]);
        chk(req, "rd_miss_cnt", int'(rd_miss_cnt), cnt_model[1]);
        chk(req, "rd_viol_cnt", int'(rd_viol_cnt), cnt_model[2]);
        chk(req, "wr_hit_cnt",  int'(wr_hit_cnt),  cnt_model[3]);
        chk(req, "wr_miss_cnt", int'(wr_miss_cnt), cnt_model[4]);
        chk(req, "wr_viol_cnt", int'(wr_viol_cnt), cnt_model[5]);
    endtask

    // Behavioural expectation; counter slot -1 means no counter moves.
    task automatic predict(output int kind, output int st, output int slot);
        int w;
        int dir_base;
        w = is_write ? 1 : 0;
        dir_base = is_write ? 3 : 0;
        kind = 0; st = 0; slot = -1;
        if ((int'(vaddr) % int'(size_bytes)) != 0) begin
            kind = 1; st = w;
        end else if (!va_ok) begin
            kind = 2; st = 2 + 16 + w; slot = dir_base + 2;
        end else if (!tb_hit) begin
            kind = pte_miss_sel ? 4 : 3; st = 32 + w; slot = dir_base + 1;
        end else if (is_write) begin
            if (!wr_en_mask[mode]) begin
                kind = 5; st = 1 + 2 + (fon_write ? 8 : 0); slot = 5;
            end else if (fon_write) begin
                kind = 6; st = 9; slot = 5;
            end else begin
                slot = 3;
            end
        end else begin
            if (!rd_en_mask[mode]) begin
                kind = 5; st = 2 + (fon_read ? 4 : 0); slot = 2;
            end else if (fon_read) begin
                kind = 6; st = 4; slot = 2;
            end else begin
                slot = 0;
            end
        end
    endtask

    task automatic access(input string req, input logic [15:0] va, input logic [3:0] sz,
                          input logic wr, input logic [1:0] md, input logic vok,
                          input logic pte, input logic ht, input logic [3:0] rm,
                          input logic [3:0] wm, input logic fr, input logic fw);
        int ek, es, slot;
        req_valid = 1'b1; vaddr = va; size_bytes = sz; is_write = wr; mode = md;
        va_ok = vok; pte_miss_sel = pte; tb_hit = ht; rd_en_mask = rm;
        wr_en_mask = wm; fon_read = fr; fon_write = fw;
        predict(ek, es, slot);
        @(posedge clk);
        if (slot >= 0) cnt_model[slot]++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "out_valid",  int'(out_valid),  1);
        chk(req, "fault",      int'(fault),      (ek != 0) ? 1 : 0);
        chk(req, "fault_kind", int'(fault_kind), ek);
        chk(req, "status",     int'(status),     es);
        chk_counters(req);
    endtask

    task automatic idle(input string req);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req, "idle out_valid",  int'(out_valid),  0);
        chk(req, "idle fault",      int'(fault),      0);
        chk(req, "idle fault_kind", int'(fault_kind), 0);
        chk(req, "idle status",     int'(status),     0);
        chk_counters(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        foreach (cnt_model[i]) cnt_model[i] = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "out_valid in reset", int'(out_valid), 0);
        chk_counters("R10");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "out_valid after reset", int'(out_valid), 0);
        chk_counters("R10");

        // R1: alignment wins even over bad address and miss
        access("R1", 16'h0003, 4'd4, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0);
        access("R1", 16'h0001, 4'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0);
        access("R1", 16'h0104, 4'd8, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0);
        // R2: bad address, beats miss
        access("R2", 16'h0010, 4'd4, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0);
        access("R2", 16'h0018, 4'd8, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0);
        // R3: miss variants
        access("R3", 16'h0020, 4'd4, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 1'b1);
        access("R3", 16'h0020, 4'd4, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0);
        // R4: write enable bit indexed by mode
        access("R4", 16'h0040, 4'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 4'hF, 4'b1011, 1'b0, 1'b1);
        access("R4", 16'h0040, 4'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 4'hF, 4'b1011, 1'b0, 1'b0);
        access("R4", 16'h0042, 4'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 4'h0, 4'b0100, 1'b0, 1'b0);
        // R5: write fault-on
        access("R5", 16'h0080, 4'd1, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 4'hF, 4'b1000, 1'b0, 1'b1);
        // R6: read enable bit indexed by mode
        access("R6", 16'h0100, 4'd4, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 4'b1101, 4'hF, 1'b1, 1'b0);
        access("R6", 16'h0100, 4'd4, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 4'b1101, 4'hF, 1'b0, 1'b0);
        // R7: read fault-on
        access("R7", 16'h0200, 4'd8, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'b0001, 4'h0, 1'b1, 1'b0);
        // R8: clean hits
        access("R8", 16'h0300, 4'd4, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0);
        access("R8", 16'h0308, 4'd8, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0);
        // R11: opposite-direction fields ignored
        access("R11", 16'h0400, 4'd4, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 4'b0001, 4'h0, 1'b0, 1'b1);
        access("R11", 16'h0400, 4'd4, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 4'h0, 4'b0001, 1'b1, 1'b0);
        // R9: idle after a verdict clears the outputs
        idle("R9");
        idle("R9");

        // Sweep of mixed accesses, back to back, compared every clock
        for (int n = 0; n < 300; n++) begin
            logic [3:0] sz;
            sz = 4'd1 << ($urandom % 4);
            access("sweep R8", 16'($urandom), sz, 1'($urandom), 2'($urandom),
                   ($urandom % 8) != 0, 1'($urandom), ($urandom % 4) != 0,
                   4'($urandom), 4'($urandom), ($urandom % 3) == 0,
                   ($urandom % 3) == 0);
            if ((n % 17) == 0) idle("sweep R9");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule